// File: doc/BRIEF.md
# Short Conditional Branch Resolver

This block resolves short self-relative control transfers for an instruction pipeline. For each strobed request it works out whether a conditional jump or a count-driven loop operation is taken. It also forms the next instruction pointer and, for the loop forms, the updated count value. The condition is evaluated from five status flags: carry, zero, sign, overflow and parity. Unsigned comparisons use carry and zero. Signed comparisons use the exclusive-or of sign and overflow, optionally combined with zero.

The jump target is the address of the following instruction (current pointer plus instruction length) plus the sign-extended 8-bit displacement. The sum wraps modulo 2^16. All results are registered and appear one clock after the request strobe. A two-state controller sequences each request. In state `S_IDLE` no result is being presented. A strobe moves the controller to `S_PRESENT` for the next cycle. The transition is named `T_ACCEPT` and applies from either state while `in_valid` is high. Without a strobe the controller returns to `S_IDLE` (transition `T_RETIRE`). While in `S_IDLE` the last result stays on the outputs.

Top module: `branch_resolver`

## Requirements
- R1: After reset is asserted, `out_valid`, `taken`, `cnt_we`, `next_ip` and `cnt_out` are all zero.
- R2: `out_valid` is high in the cycle right after each cycle with `in_valid` high, and low otherwise; all results belong to that strobe.
- R3: Base test encoding, selected by `cond_sel[3:1]`:
  - 0 = overflow
  - 1 = carry
  - 2 = zero
  - 3 = carry OR zero
  - 4 = sign
  - 5 = parity (set means even)
  - 6 = sign XOR overflow
  - 7 = (sign XOR overflow) OR zero
- R4: `cond_sel[0]=1` inverts the base test, so that each pair forms a condition and its negation. For example, 7 is "above" and 15 is "greater".
- R5: A taken transfer gives `next_ip = ip_in + insn_len + sign_extend(disp)` modulo 2^16. This covers the displacement extremes -128 and +127.
- R6: A transfer that is not taken gives `next_ip = ip_in + insn_len` modulo 2^16.
- R7: `loop_op` encoding: 0 = conditional jump, 1 = loop, 2 = loop while zero, 3 = loop while not zero, 4 = jump if count zero, 5..7 = reserved. For `loop_op` 0, `taken` is the `cond_sel` result, `cnt_we` is 0 and `cnt_out` equals `cnt_in`.
- R8: For `loop_op` 1, 2 and 3, `cnt_out = cnt_in - 1` (wrapping, so 0 gives 0xFFFF) with `cnt_we=1`. The transfer is taken only if the new count is nonzero. Op 2 additionally needs zero=1, and op 3 additionally needs zero=0.
- R9: For `loop_op` 4, the transfer is taken exactly when `cnt_in` is 0; `cnt_we=0` and `cnt_out=cnt_in`.
- R10: For reserved `loop_op` values 5..7, `taken=0`, `cnt_we=0` and `cnt_out=cnt_in`.
- R11: In a cycle after `in_valid` low, `out_valid` is 0 and `next_ip`, `cnt_out`, `taken` and `cnt_we` hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| cond_sel | input | 4 | Condition selector |
| flag_cf | input | 1 | Carry flag |
| flag_zf | input | 1 | Zero flag |
| flag_sf | input | 1 | Sign flag |
| flag_of | input | 1 | Overflow flag |
| flag_pf | input | 1 | Parity flag |
| loop_op | input | 3 | Loop-operation selector |
| ip_in | input | 16 | Current instruction pointer |
| insn_len | input | 4 | Instruction length in bytes |
| disp | input | 8 | Signed displacement |
| cnt_in | input | 16 | Count register value |
| out_valid | output | 1 | Result valid |
| next_ip | output | 16 | Next instruction pointer |
| cnt_out | output | 16 | Updated count value |
| cnt_we | output | 1 | Count write enable |
| taken | output | 1 | Transfer taken |

## Verification
On every cycle, the assertions check the following:
- The one-cycle latency and the idle hold of the outputs.
- That a fall-through pointer appears whenever the transfer is not taken.
- That a taken decrementing loop never presents a zero count.
- That plain jumps and reserved operations never write the count.

Some behaviour can only be shown by the bench's scenarios, which compare against an independent model:
- The flag-to-condition mapping for all sixteen selectors.
- The exact target arithmetic at the displacement extremes and at address wrap.
- The count corner cases 0 and 1.

// File: rtl/br_pkg.sv
package br_pkg;
    typedef enum logic [2:0] {
        LOP_NONE  = 3'd0,
        LOP_DEC   = 3'd1,
        LOP_DEC_Z = 3'd2,
        LOP_DEC_NZ= 3'd3,
        LOP_CZERO = 3'd4
    } loop_op_e;

    typedef enum logic [2:0] {
        BT_OV     = 3'd0,
        BT_CY     = 3'd1,
        BT_ZR     = 3'd2,
        BT_CY_ZR  = 3'd3,
        BT_SG     = 3'd4,
        BT_PAR    = 3'd5,
        BT_LT     = 3'd6,
        BT_LE     = 3'd7
    } base_test_e;

    typedef enum logic {
        S_IDLE    = 1'b0,
        S_PRESENT = 1'b1
    } ctl_state_e;

    typedef struct packed {
        logic cf;
        logic zf;
        logic sf;
        logic of;
        logic pf;
    } flags_t;
endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval
    import br_pkg::*;
(
    input  logic [3:0] sel,
    input  flags_t     fl,
    output logic       hit
);
    logic       base;
    base_test_e bsel;
    logic       lt_sig;

    assign bsel   = base_test_e'(sel[3:1]);
    assign lt_sig = fl.sf ^ fl.of;

    always_comb begin
        unique case (bsel)
            BT_OV:    base = fl.of;
            BT_CY:    base = fl.cf;
            BT_ZR:    base = fl.zf;
            BT_CY_ZR: base = fl.cf | fl.zf;
            BT_SG:    base = fl.sf;
            BT_PAR:   base = fl.pf;
            BT_LT:    base = lt_sig;
            BT_LE:    base = lt_sig | fl.zf;
            default:  base = 1'b0;
        endcase
    end

    assign hit = base ^ sel[0];
endmodule

// File: rtl/br_target_calc.sv
module br_target_calc #(
    parameter int IP_W   = 16,
    parameter int LEN_W  = 4,
    parameter int DISP_W = 8
) (
    input  logic [IP_W-1:0]   ip,
    input  logic [LEN_W-1:0]  len,
    input  logic [DISP_W-1:0] disp,
    output logic [IP_W-1:0]   fall_ip,
    output logic [IP_W-1:0]   jump_ip
);
    localparam int EXT_W = IP_W - DISP_W;
    localparam int PAD_W = IP_W - LEN_W;

    logic [IP_W-1:0] disp_ext;
    logic [IP_W-1:0] len_ext;

    generate
        if (EXT_W > 0) begin : g_sext
            assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
        end else begin : g_trunc
            assign disp_ext = disp[IP_W-1:0];
        end
        if (PAD_W > 0) begin : g_lpad
            assign len_ext = {{PAD_W{1'b0}}, len};
        end else begin : g_lcut
            assign len_ext = len[IP_W-1:0];
        end
    endgenerate

    assign fall_ip = ip + len_ext;
    assign jump_ip = fall_ip + disp_ext;
endmodule

// File: rtl/br_loop_ctl.sv
module br_loop_ctl
    import br_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [2:0]       op,
    input  logic             cond_hit,
    input  logic             zf,
    input  logic [CNT_W-1:0] cnt,
    output logic             take,
    output logic             wr,
    output logic [CNT_W-1:0] cnt_nxt
);
    logic [CNT_W-1:0] dec;
    logic             dec_nz;
    logic             cnt_z;

    assign dec    = cnt - CNT_W'(1);
    assign dec_nz = |dec;
    assign cnt_z  = ~|cnt;

    always_comb begin
        take    = 1'b0;
        wr      = 1'b0;
        cnt_nxt = cnt;
        unique case (op)
            LOP_NONE:   take = cond_hit;
            LOP_DEC:    begin wr = 1'b1; cnt_nxt = dec; take = dec_nz; end
            LOP_DEC_Z:  begin wr = 1'b1; cnt_nxt = dec; take = dec_nz & zf; end
            LOP_DEC_NZ: begin wr = 1'b1; cnt_nxt = dec; take = dec_nz & ~zf; end
            LOP_CZERO:  take = cnt_z;
            default:    take = 1'b0;
        endcase
    end
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
    import br_pkg::*;
#(
    parameter int IP_W   = 16,
    parameter int LEN_W  = 4,
    parameter int DISP_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        cond_sel,
    input  logic              flag_cf,
    input  logic              flag_zf,
    input  logic              flag_sf,
    input  logic              flag_of,
    input  logic              flag_pf,
    input  logic [2:0]        loop_op,
    input  logic [IP_W-1:0]   ip_in,
    input  logic [LEN_W-1:0]  insn_len,
    input  logic [DISP_W-1:0] disp,
    input  logic [CNT_W-1:0]  cnt_in,
    output logic              out_valid,
    output logic [IP_W-1:0]   next_ip,
    output logic [CNT_W-1:0]  cnt_out,
    output logic              cnt_we,
    output logic              taken
);
    flags_t           fl;
    logic             c_hit;
    logic [IP_W-1:0]  fall_ip;
    logic [IP_W-1:0]  jump_ip;
    logic             l_take;
    logic             l_wr;
    logic [CNT_W-1:0] l_cnt;
    ctl_state_e       state, state_nxt;

    assign fl = '{cf: flag_cf, zf: flag_zf, sf: flag_sf, of: flag_of, pf: flag_pf};

    br_cond_eval u_cond (
        .sel (cond_sel),
        .fl  (fl),
        .hit (c_hit)
    );

    br_target_calc #(.IP_W(IP_W), .LEN_W(LEN_W), .DISP_W(DISP_W)) u_tgt (
        .ip      (ip_in),
        .len     (insn_len),
        .disp    (disp),
        .fall_ip (fall_ip),
        .jump_ip (jump_ip)
    );

    br_loop_ctl #(.CNT_W(CNT_W)) u_loop (
        .op       (loop_op),
        .cond_hit (c_hit),
        .zf       (flag_zf),
        .cnt      (cnt_in),
        .take     (l_take),
        .wr       (l_wr),
        .cnt_nxt  (l_cnt)
    );

    // Controller: T_ACCEPT on a strobe, T_RETIRE otherwise
    always_comb begin
        unique case (state)
            S_IDLE:    state_nxt = in_valid ? S_PRESENT : S_IDLE;
            S_PRESENT: state_nxt = in_valid ? S_PRESENT : S_IDLE;
            default:   state_nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    assign out_valid = (state == S_PRESENT);

    // Result registers, loaded on T_ACCEPT
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_ip <= '0;
            cnt_out <= '0;
            cnt_we  <= 1'b0;
            taken   <= 1'b0;
        end else if (in_valid) begin
            next_ip <= l_take ? jump_ip : fall_ip;
            cnt_out <= l_cnt;
            cnt_we  <= l_wr;
            taken   <= l_take;
        end
    end

    // R2
    strobe_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    no_spur_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R6
    fall_ip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (taken || next_ip == $past(fall_ip)));
    // R8
    loop_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cnt_we && taken) |-> (cnt_out != '0));
    // R7
    plain_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && loop_op == LOP_NONE) |=> !cnt_we);
    // R10
    rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && loop_op > LOP_CZERO) |=> (!taken && !cnt_we));
    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(next_ip) && $stable(cnt_out) && $stable(taken) && $stable(cnt_we)));
endmodule

// File: tb/sim_branch_resolver.sv
`timescale 1ns/1ps
module sim_branch_resolver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  cond_sel = '0;
    logic        flag_cf = 0, flag_zf = 0, flag_sf = 0, flag_of = 0, flag_pf = 0;
    logic [2:0]  loop_op = '0;
    logic [15:0] ip_in = '0;
    logic [3:0]  insn_len = '0;
    logic [7:0]  disp = '0;
    logic [15:0] cnt_in = '0;
    logic        out_valid;
    logic [15:0] next_ip;
    logic [15:0] cnt_out;
    logic        cnt_we;
    logic        taken;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    branch_resolver u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cond_sel(cond_sel),
        .flag_cf(flag_cf), .flag_zf(flag_zf), .flag_sf(flag_sf),
        .flag_of(flag_of), .flag_pf(flag_pf), .loop_op(loop_op),
        .ip_in(ip_in), .insn_len(insn_len), .disp(disp), .cnt_in(cnt_in),
        .out_valid(out_valid), .next_ip(next_ip), .cnt_out(cnt_out),
        .cnt_we(cnt_we), .taken(taken)
    );

    function automatic bit ref_cond(input logic [3:0] s, input bit cf, zf, sf, of, pf);
        bit b;
        case (s[3:1])
            3'd0: b = of;
            3'd1: b = cf;
            3'd2: b = zf;
            3'd3: b = cf | zf;
            3'd4: b = sf;
            3'd5: b = pf;
            3'd6: b = sf ^ of;
            default: b = (sf ^ of) | zf;
        endcase
        return b ^ s[0];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] s, input bit cf, zf, sf, of, pf,
                         input logic [2:0] op, input logic [15:0] ip,
                         input logic [3:0] ln, input logic [7:0] d, input logic [15:0] c);
        bit e_tk, e_we;
        logic [15:0] e_cnt, e_ip, fall, dec;
        fall = ip + {12'd0, ln};
        dec = c - 16'd1;
        e_we = 0; e_cnt = c;
        case (op)
            3'd0: e_tk = ref_cond(s, cf, zf, sf, of, pf);
            3'd1: begin e_we = 1; e_cnt = dec; e_tk = (dec != 0); end
            3'd2: begin e_we = 1; e_cnt = dec; e_tk = (dec != 0) && zf; end
            3'd3: begin e_we = 1; e_cnt = dec; e_tk = (dec != 0) && !zf; end
            3'd4: e_tk = (c == 0);
            default: e_tk = 0;
        endcase
        e_ip = e_tk ? fall + {{8{d[7]}}, d} : fall;
        @(negedge clk);
        in_valid = 1; cond_sel = s; flag_cf = cf; flag_zf = zf; flag_sf = sf;
        flag_of = of; flag_pf = pf; loop_op = op; ip_in = ip; insn_len = ln;
        disp = d; cnt_in = c;
        @(negedge clk);
        in_valid = 0;
        chk("R2 out_valid", {31'd0, out_valid}, 32'd1);
        if (op == 0)      chk("R3/R4 taken", {31'd0, taken}, {31'd0, e_tk});
        else if (op <= 3) chk("R8 taken", {31'd0, taken}, {31'd0, e_tk});
        else if (op == 4) chk("R9 taken", {31'd0, taken}, {31'd0, e_tk});
        else              chk("R10 taken", {31'd0, taken}, {31'd0, e_tk});
        chk(e_tk ? "R5 next_ip" : "R6 next_ip", {16'd0, next_ip}, {16'd0, e_ip});
        chk((op >= 1 && op <= 3) ? "R8 cnt" : "R7 cnt", {15'd0, cnt_we, cnt_out}, {15'd0, e_we, e_cnt});
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] h_ip, h_cnt;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset", {13'd0, out_valid, taken, cnt_we, 16'd0}, 32'd0);
        chk("R1 regs", {next_ip, cnt_out}, 32'd0);
        rst_n = 1;
        // R3 R4 directed: all selectors, all flag combos
        for (int s = 0; s < 16; s++)
            for (int f = 0; f < 32; f++)
                apply(s[3:0], f[0], f[1], f[2], f[3], f[4], 3'd0, 16'h1000, 4'd2, 8'h10, 16'd5);
        // R5 displacement extremes and wrap
        apply(4'd4, 0, 1, 0, 0, 0, 3'd0, 16'h2000, 4'd2, 8'h80, 16'd0);
        apply(4'd4, 0, 1, 0, 0, 0, 3'd0, 16'h2000, 4'd2, 8'h7F, 16'd0);
        apply(4'd4, 0, 1, 0, 0, 0, 3'd0, 16'hFFF0, 4'd3, 8'h7F, 16'd0);
        apply(4'd4, 0, 1, 0, 0, 0, 3'd0, 16'h0010, 4'd2, 8'h80, 16'd0);
        // R6 fall-through wrap
        apply(4'd5, 0, 1, 0, 0, 0, 3'd0, 16'hFFFE, 4'd4, 8'h20, 16'd0);
        // R8 count corners
        apply(4'd0, 0, 0, 0, 0, 0, 3'd1, 16'h0100, 4'd2, 8'hF0, 16'd1);
        apply(4'd0, 0, 0, 0, 0, 0, 3'd1, 16'h0100, 4'd2, 8'hF0, 16'd0);
        apply(4'd0, 0, 1, 0, 0, 0, 3'd2, 16'h0100, 4'd2, 8'hF0, 16'd7);
        apply(4'd0, 0, 0, 0, 0, 0, 3'd2, 16'h0100, 4'd2, 8'hF0, 16'd7);
        apply(4'd0, 0, 0, 0, 0, 0, 3'd3, 16'h0100, 4'd2, 8'hF0, 16'd7);
        apply(4'd0, 0, 1, 0, 0, 0, 3'd3, 16'h0100, 4'd2, 8'hF0, 16'd7);
        // R9
        apply(4'd1, 0, 0, 0, 0, 0, 3'd4, 16'h0300, 4'd2, 8'h05, 16'd0);
        apply(4'd1, 0, 0, 0, 0, 0, 3'd4, 16'h0300, 4'd2, 8'h05, 16'd1);
        // R10
        for (int o = 5; o < 8; o++)
            apply(4'd1, 0, 0, 0, 0, 0, o[2:0], 16'h0400, 4'd2, 8'h05, 16'd0);
        // R11 hold with idle cycles and changing inputs
        h_ip = next_ip; h_cnt = cnt_out;
        @(negedge clk);
        ip_in = 16'hABCD; cnt_in = 16'h1234; loop_op = 3'd1; cond_sel = 4'd1;
        @(negedge clk);
        chk("R11 out_valid", {31'd0, out_valid}, 32'd0);
        chk("R11 hold", {next_ip, cnt_out}, {h_ip, h_cnt});
        // random mix
        for (int i = 0; i < 3000; i++)
            apply($urandom % 16, $urandom % 2, $urandom % 2, $urandom % 2,
                  $urandom % 2, $urandom % 2, $urandom % 8, $urandom,
                  $urandom % 16, $urandom, ($urandom % 4 == 0) ? $urandom % 2 : $urandom);
        // R1 reset again mid-run
        rst_n = 0;
        @(negedge clk);
        chk("R1 re-reset", {13'd0, out_valid, taken, cnt_we, next_ip}, 32'd0);
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule